// File: doc/BRIEF.md
# Rank-Indexed Nearest-Candidate Queue

This block holds up to 128 (key, tag) candidates for a nearest-neighbour search engine. It keeps them ordered by key, and the smallest key ranks best. Entries never move. Each sits in a fixed physical slot with its own key, tag and rank register. An offered key is compared against every stored key in the same cycle. Each slot then decides on its own whether its rank stays put or grows by one.

The insert runs in two register stages. In the acceptance cycle, the post-insert rank of every stored entry is decoded into an occupancy bitmap, and that bitmap is registered. On the following edge, the lowest clear bit of the bitmap becomes the new entry's rank, and the ranks are updated. The new entry is written to the lowest empty slot. If the queue is full, it goes instead into the slot whose entry was pushed past the last rank. An offered key that would itself land past the last rank is discarded.

A read port takes a rank and returns the entry holding it, with a hit flag. A clear input empties the queue in one cycle.

Top module: `nn_rank_queue`

## Requirements
- R1: After reset the queue is empty: `rd_hit` is 0 for every rank and `in_ready` is 1.
- R2: An accepted key K gets the rank equal to the number of stored keys less than or equal to K. Every stored entry with a key strictly greater than K moves down one rank. Among equal keys, the older entry keeps the better (lower) rank.
- R3: For a rank r below the current entry count, the read port returns `rd_hit`=1 with the key and tag of the entry at rank r. Otherwise it returns `rd_hit`=0.
- R4: When the queue holds DEPTH entries and the accepted key is smaller than the key at rank DEPTH-1, the entry at rank DEPTH-1 is removed. The new entry takes its rank position as in R2, and the count stays DEPTH.
- R5: When the queue holds DEPTH entries and the accepted key is greater than or equal to the key at rank DEPTH-1, the insert is discarded. Every rank keeps its key and tag.
- R6: An insert is accepted on a rising edge where `in_valid` and `in_ready` are both 1. It is visible on the read port after the next rising edge. `in_ready` is 0 during the cycle between those two edges.
- R7: A rising edge with `clear`=1 empties the queue and cancels any insert in flight. `in_ready` is 0 while `clear` is 1.
- R8: No two stored entries share a rank, so at most one entry answers any read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| clear | input | 1 | Empties the queue on the next edge |
| in_valid | input | 1 | Insert request |
| in_ready | output | 1 | Insert can be accepted this cycle |
| in_key | input | KEY_W | Key of the offered entry; smaller is better |
| in_tag | input | TAG_W | Payload carried with the key |
| rd_rank | input | log2(DEPTH) | Rank to look up |
| rd_hit | output | 1 | An entry holds `rd_rank` |
| rd_key | output | KEY_W | Key at `rd_rank` (0 on a miss) |
| rd_tag | output | TAG_W | Tag at `rd_rank` (0 on a miss) |

## Verification
A wrong rank bump or a wrong pick from the vacancy bitmap appears on the read port one edge after the insert is committed. It shows up as a key out of order, a tag swapped between equal keys, or two ranks answering the same read. A slot that fails to evict or that overwrites a live entry changes the entry count, so a later read at a high rank reports a hit or miss the model does not expect. The bench compares the read port against its ordered model on every cycle and sweeps every rank after each phase, so a corrupted rank cannot stay hidden for longer than one sweep.

// File: rtl/nrq_pkg.sv
package nrq_pkg;
   typedef enum logic {
      ST_IDLE   = 1'b0,
      ST_COMMIT = 1'b1
   } stage_e;
endpackage

// File: rtl/nrq_first_one.sv
module nrq_first_one #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          found
);
   // lowest set bit wins: scan from the top so the last hit is the lowest
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx   = IW'(i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/nrq_slot.sv
module nrq_slot #(
   parameter int KEY_W  = 16,
   parameter int TAG_W  = 8,
   parameter int RANK_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              cap,
   input  logic [KEY_W-1:0]  probe_key,
   input  logic              commit,
   input  logic              write,
   input  logic [KEY_W-1:0]  wr_key,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [RANK_W-1:0] wr_rank,
   output logic              valid_o,
   output logic [KEY_W-1:0]  key_o,
   output logic [TAG_W-1:0]  tag_o,
   output logic [RANK_W-1:0] rank_o,
   output logic [RANK_W:0]   post_o,
   output logic              drop_o
);
   localparam logic [RANK_W-1:0] LAST = '1;

   logic              valid_q;
   logic [KEY_W-1:0]  key_q;
   logic [TAG_W-1:0]  tag_q;
   logic [RANK_W-1:0] rank_q;
   logic              bump_q;
   logic              bump_now;

   // strictly smaller new key pushes this entry one rank down
   assign bump_now = valid_q && (probe_key < key_q);
   assign post_o   = {1'b0, rank_q} + {{RANK_W{1'b0}}, bump_now};
   assign drop_o   = commit && bump_q && (rank_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         key_q   <= '0;
         tag_q   <= '0;
         rank_q  <= '0;
         bump_q  <= 1'b0;
      end else if (clear) begin
         valid_q <= 1'b0;
         bump_q  <= 1'b0;
      end else begin
         if (cap) bump_q <= bump_now;
         if (write) begin
            valid_q <= 1'b1;
            key_q   <= wr_key;
            tag_q   <= wr_tag;
            rank_q  <= wr_rank;
         end else if (commit && bump_q) begin
            if (rank_q == LAST) valid_q <= 1'b0;
            else                rank_q  <= rank_q + 1'b1;
         end
      end
   end

   assign valid_o = valid_q;
   assign key_o   = key_q;
   assign tag_o   = tag_q;
   assign rank_o  = rank_q;
endmodule

// File: rtl/nn_rank_queue.sv
module nn_rank_queue #(
   parameter int DEPTH  = 128,
   parameter int KEY_W  = 16,
   parameter int TAG_W  = 8,
   parameter int RANK_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [KEY_W-1:0]  in_key,
   input  logic [TAG_W-1:0]  in_tag,
   input  logic [RANK_W-1:0] rd_rank,
   output logic              rd_hit,
   output logic [KEY_W-1:0]  rd_key,
   output logic [TAG_W-1:0]  rd_tag
);
   import nrq_pkg::*;

   localparam logic [RANK_W:0] LIMIT = (RANK_W + 1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (RANK_W != $clog2(DEPTH)) begin : g_bad_rank
      $error("RANK_W must equal clog2(DEPTH)");
   end
   if (KEY_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("KEY_W and TAG_W must be positive");
   end

   stage_e            stage_q;
   logic [KEY_W-1:0]  key_q;
   logic [TAG_W-1:0]  tag_q;
   logic [DEPTH-1:0]  occ_q, occ_d;
   logic              accept, commit, busy;

   logic [DEPTH-1:0]  slot_valid, drop, write_vec, rd_match, free_vec;
   logic [KEY_W-1:0]  slot_key  [DEPTH];
   logic [TAG_W-1:0]  slot_tag  [DEPTH];
   logic [RANK_W-1:0] slot_rank [DEPTH];
   logic [RANK_W:0]   slot_post [DEPTH];

   logic [RANK_W-1:0] new_rank, wr_slot;
   logic              has_vac, has_free;

   assign busy     = (stage_q == ST_COMMIT);
   assign in_ready = !busy && !clear;
   assign accept   = in_valid && in_ready;
   assign commit   = busy && !clear;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign write_vec[g] = commit && has_vac && has_free && (wr_slot == RANK_W'(g));
      assign rd_match[g]  = slot_valid[g] && (slot_rank[g] == rd_rank);

      nrq_slot #(.KEY_W(KEY_W), .TAG_W(TAG_W), .RANK_W(RANK_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (clear),
         .cap       (accept),
         .probe_key (in_key),
         .commit    (commit),
         .write     (write_vec[g]),
         .wr_key    (key_q),
         .wr_tag    (tag_q),
         .wr_rank   (new_rank),
         .valid_o   (slot_valid[g]),
         .key_o     (slot_key[g]),
         .tag_o     (slot_tag[g]),
         .rank_o    (slot_rank[g]),
         .post_o    (slot_post[g]),
         .drop_o    (drop[g])
      );
   end

   // stage one: decode the post-insert rank of every live entry
   always_comb begin
      occ_d = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (slot_valid[i] && (slot_post[i] < LIMIT))
            occ_d[slot_post[i][RANK_W-1:0]] = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_q <= ST_IDLE;
         key_q   <= '0;
         tag_q   <= '0;
         occ_q   <= '0;
      end else if (clear) begin
         stage_q <= ST_IDLE;
      end else if (accept) begin
         stage_q <= ST_COMMIT;
         key_q   <= in_key;
         tag_q   <= in_tag;
         occ_q   <= occ_d;
      end else begin
         stage_q <= ST_IDLE;
      end
   end

   // stage two: the single hole in the bitmap is the new rank
   nrq_first_one #(.N(DEPTH), .IW(RANK_W)) u_vacancy (
      .vec   (~occ_q),
      .idx   (new_rank),
      .found (has_vac)
   );

   assign free_vec = ~slot_valid | drop;

   nrq_first_one #(.N(DEPTH), .IW(RANK_W)) u_slot_pick (
      .vec   (free_vec),
      .idx   (wr_slot),
      .found (has_free)
   );

   always_comb begin
      rd_hit = 1'b0;
      rd_key = '0;
      rd_tag = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_match[i]) begin
            rd_hit = 1'b1;
            rd_key = rd_key | slot_key[i];
            rd_tag = rd_tag | slot_tag[i];
         end
      end
   end
endmodule

// File: rtl/nn_rank_queue_chk.sv
module nn_rank_queue_chk #(
   parameter int DEPTH = 128
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clear,
   input logic             in_valid,
   input logic             in_ready,
   input logic             busy,
   input logic [DEPTH-1:0] slot_valid,
   input logic [DEPTH-1:0] rd_match
);
   p_stall_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);

   p_commit_single_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (slot_valid == '0));

   p_rank_unique_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_match));

   p_grow_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ($countones(slot_valid) <= $past($countones(slot_valid)) + 1));

   p_full_stays_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($countones(slot_valid) == DEPTH) && !clear) |=> ($countones(slot_valid) == DEPTH));
endmodule

bind nn_rank_queue nn_rank_queue_chk #(.DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .clear      (clear),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .busy       (busy),
   .slot_valid (slot_valid),
   .rd_match   (rd_match)
);

// File: tb/nn_rank_queue_bench.sv
`timescale 1ns/1ps
module nn_rank_queue_bench;
   localparam int DEPTH  = 128;
   localparam int KEY_W  = 16;
   localparam int TAG_W  = 8;
   localparam int RANK_W = 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              clear = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [KEY_W-1:0]  in_key = '0;
   logic [TAG_W-1:0]  in_tag = '0;
   logic [RANK_W-1:0] rd_rank = '0;
   logic              rd_hit;
   logic [KEY_W-1:0]  rd_key;
   logic [TAG_W-1:0]  rd_tag;

   always #5 clk = ~clk;

   nn_rank_queue #(.DEPTH(DEPTH), .KEY_W(KEY_W), .TAG_W(TAG_W)) u_nn_rank_queue (
      .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid), .in_ready(in_ready),
      .in_key(in_key), .in_tag(in_tag), .rd_rank(rd_rank), .rd_hit(rd_hit),
      .rd_key(rd_key), .rd_tag(rd_tag)
   );

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   // ordered model: index = rank
   int mk[$];
   int mt[$];
   bit pend = 0;
   int pk = 0;
   int pt = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_apply();
      int pos = 0;
      foreach (mk[i]) if (mk[i] <= pk) pos++;
      mk.insert(pos, pk);
      mt.insert(pos, pt);
      if (mk.size() > DEPTH) begin
         void'(mk.pop_back());
         void'(mt.pop_back());
      end
   endtask

   task automatic check_read(input int rr, input string req);
      bit eh = (rr < mk.size());
      chk(req, "rd_hit", int'(rd_hit), int'(eh));
      if (eh) begin
         chk(req, "rd_key", int'(rd_key), mk[rr]);
         chk(req, "rd_tag", int'(rd_tag), mt[rr]);
      end
   endtask

   task automatic step(input bit v, input int k, input int t, input bit clr,
                       input int rr, input string req, output bit acc);
      bit exp_rdy;
      in_valid = v;
      in_key   = KEY_W'(k);
      in_tag   = TAG_W'(t);
      clear    = clr;
      rd_rank  = RANK_W'(rr);
      #1;
      exp_rdy = !pend && !clr;
      chk(clr ? "R7" : "R6", "in_ready", int'(in_ready), int'(exp_rdy));
      acc = v && exp_rdy;
      @(posedge clk);
      if (clr) begin
         mk.delete();
         mt.delete();
         pend = 0;
      end else begin
         if (pend) model_apply();
         pend = acc;
         pk = k;
         pt = t;
      end
      @(negedge clk);
      check_read(rr, req);
   endtask

   task automatic idle(input int rr, input string req);
      bit a;
      step(0, 0, 0, 0, rr, req, a);
   endtask

   task automatic push(input int k, input int t, input int rr, input string req);
      bit a = 0;
      while (!a) step(1, k, t, 0, rr, req, a);
   endtask

   task automatic sweep(input string req);
      for (int r = 0; r < DEPTH; r++) idle(r, req);
   endtask

   initial begin
      bit a;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1", "in_ready after reset", int'(in_ready), 1);
      @(negedge clk);
      idle(0, "R1");
      idle(DEPTH - 1, "R1");

      // ties and ordering, isolated inserts
      push(50, 1, 0, "R2"); idle(0, "R2");
      push(50, 2, 1, "R2"); idle(1, "R2");
      push(20, 3, 0, "R2"); idle(2, "R2");
      push(80, 4, 3, "R2"); idle(3, "R2");
      push(50, 5, 3, "R2"); idle(3, "R2");
      for (int r = 0; r < 7; r++) idle(r, "R2");

      // back-to-back requests: ready drops for one cycle after each accept
      for (int i = 0; i < 20; i++) push(100 - 3 * i, 10 + i, i % 8, "R6");
      sweep("R3");

      // fill past capacity with random keys, many ties
      for (int i = 0; i < 140; i++) push($urandom_range(0, 999), i & 255, i % DEPTH, "R3");
      idle(0, "R3");
      chk("R4", "model full", mk.size(), DEPTH);

      // full queue: smaller key evicts the worst entry
      push(0, 201, DEPTH - 1, "R4"); idle(DEPTH - 1, "R4");
      push(mk[DEPTH - 1] - 1, 202, DEPTH - 1, "R4"); idle(DEPTH - 1, "R4");
      // full queue: larger or equal key to the worst is discarded
      push(65535, 203, DEPTH - 1, "R5"); idle(DEPTH - 1, "R5");
      push(mk[DEPTH - 1], 204, DEPTH - 1, "R5"); idle(DEPTH - 1, "R5");
      sweep("R5");

      // clear aborts an insert in flight
      push(7, 99, 0, "R7");
      step(1, 8, 98, 1, 0, "R7", a);
      idle(0, "R7");
      idle(1, "R7");
      sweep("R7");

      // refill after clear
      for (int i = 0; i < 10; i++) push((i * 37) % 11, 150 + i, i, "R2");
      for (int r = 0; r < 12; r++) idle(r, "R8");

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog run did not finish actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule